// File: doc/BRIEF.md
# Private-First Slot Bitmap Allocator

This block hands out runs of contiguous slots in a local scratch memory. The memory is split into equal regions, and each region holds a fixed number of slots. A requester presents its queue number, whether it owns a private region (and which one), and how many adjacent slots it needs. The block first searches that queue's private bitmap and then a shared bitmap covering the whole memory. It answers with the global index of the first slot in the run.

When neither bitmap has room, the request is held off until a run is returned to the shared pool. A separate release port returns runs. A release goes to the private bitmap of the releasing queue when its start slot lies in that queue's private region. Otherwise it goes to the shared bitmap. Regions that must never be handed out from the shared pool, such as regions owned privately or kept for special use, are marked fully busy in the shared bitmap at reset.

Top module: `slot_alloc`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In the next cycle `grant_valid` is high for exactly one cycle and `grant_slot` holds the first slot of the run. `req_ready` is low whenever `req_valid` is low.
- R2: When `req_has_priv` is 1 and the private bitmap of `req_queue` has a fitting run, that run is granted even if the shared pool also has room. The granted index is `req_priv_region * SLOTS_PER_REGION + offset`.
- R3: When the queue has no private region (`req_has_priv` = 0), or its private bitmap has no fitting run, the shared bitmap over all slots 0 to `NUM_REGIONS*SLOTS_PER_REGION-1` is searched.
- R4: Both searches take the lowest starting index whose `req_count` slots are all free. A run never extends past the end of the bitmap being searched. For a private bitmap that end is the last slot of its region; for the shared bitmap it is the last slot of the memory.
- R5: Granted slots become busy only in the bitmap that supplied them. A repeat of the same request therefore gets the next free run.
- R6: A request that finds no run gets `req_ready` low. It stays refused while `req_valid` is held, even if a release to a private bitmap frees enough room, until a release to the shared bitmap occurs.
- R7: A release to the shared bitmap wakes a refused request. The search is retried in the cycle after the release edge, against the updated bitmaps.
- R8: A release is routed as follows. If `rel_has_priv` is 1 and `rel_start / SLOTS_PER_REGION` equals `rel_priv_region`, the run at offset `rel_start % SLOTS_PER_REGION` is freed in the private bitmap of `rel_queue`. Otherwise `rel_count` slots from `rel_start` are freed in the shared bitmap.
- R9: Each bit of `region_reserved` that is 1 while reset is applied marks all slots of that region (bit i covers slots `i*SLOTS_PER_REGION` up to `(i+1)*SLOTS_PER_REGION-1`) busy in the shared bitmap. No shared grant ever lands in such a region.
- R10: After reset, `grant_valid` is 0 and every private bitmap is entirely free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| region_reserved | input | NUM_REGIONS | Regions kept out of the shared pool, sampled during reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Request accepted this cycle |
| req_queue | input | $clog2(NUM_QUEUES) | Requesting queue |
| req_has_priv | input | 1 | Requesting queue owns a private region |
| req_priv_region | input | $clog2(NUM_REGIONS) | Private region of the requesting queue |
| req_count | input | $clog2(MAX_RUN+1) | Slots wanted, 1 to MAX_RUN |
| grant_valid | output | 1 | Grant pulse, one cycle after acceptance |
| grant_slot | output | $clog2(NUM_REGIONS*SLOTS_PER_REGION) | First slot of the granted run |
| rel_valid | input | 1 | Release present this cycle |
| rel_queue | input | $clog2(NUM_QUEUES) | Releasing queue |
| rel_has_priv | input | 1 | Releasing queue owns a private region |
| rel_priv_region | input | $clog2(NUM_REGIONS) | Private region of the releasing queue |
| rel_start | input | $clog2(NUM_REGIONS*SLOTS_PER_REGION) | First slot of the run being freed |
| rel_count | input | $clog2(MAX_RUN+1) | Slots being freed |

## Verification
The bench targets several corner cases, each of which a faulty design would show differently:
- A private region with a single free slot at its top. A design that lets runs wrap or cross a region edge would grant inside the region instead of falling back to the shared pool.
- A request refused while a private release frees a fitting run. A design that wakes on any release would grant early.
- The wake-up after a shared release. A design that loses the wake-up would hang the requester.
- Releases that must land in one bitmap or the other. Misrouting them shows up as a later grant at the wrong index.
- Seeded random requests and releases, run against a bench model of both bitmaps, also catch a search that is not lowest-first and shared grants that reach a reserved region.

// File: rtl/slot_alloc_pkg.sv
// Package: shared helpers for the slot allocator.
// Assumes: callers pass non-negative integer positions.
package slot_alloc_pkg;

    // Tells whether position pos lies inside the run [start, start+cnt).
    function automatic logic run_covers(input int pos, input int start, input int cnt);
        return (pos >= start) && (pos < start + cnt);
    endfunction

endpackage

// File: rtl/slot_run_finder.sv
// Module: slot_run_finder
// Finds the lowest index where `count` consecutive bits of `map` are zero.
// A run may not pass the top of the map. Purely combinational; the clock
// and reset only qualify the checks.
// Assumes: 1 <= count <= MAX_RUN.
module slot_run_finder #(
    parameter int WIDTH   = 16,
    parameter int MAX_RUN = 4,
    parameter int CNT_W   = $clog2(MAX_RUN + 1),
    parameter int IDX_W   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] map,
    input  logic [CNT_W-1:0] count,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    localparam int PAD_W = WIDTH + MAX_RUN;

    logic [PAD_W-1:0] padded;
    logic [WIDTH-1:0] fits;

    // Bits above the map read as busy so no run passes the top.
    assign padded = {{MAX_RUN{1'b1}}, map};

    // Mark every start position whose wanted bits are all free.
    always_comb begin
        for (int p = 0; p < WIDTH; p++) begin
            fits[p] = 1'b1;
            for (int k = 0; k < MAX_RUN; k++) begin
                if ((k < int'(count)) && padded[p + k]) begin
                    fits[p] = 1'b0;
                end
            end
        end
    end

    // Priority-encode the lowest fitting position.
    always_comb begin
        found = |fits;
        idx   = '0;
        for (int p = WIDTH - 1; p >= 0; p--) begin
            if (fits[p]) begin
                idx = IDX_W'(p);
            end
        end
    end

    AST_RUN_INSIDE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (int'(idx) + int'(count) <= WIDTH)); // R4

    AST_RUN_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (((map >> idx) & ~({WIDTH{1'b1}} << count)) == '0)); // R4

endmodule

// File: rtl/slot_bitmap.sv
// Module: slot_bitmap
// Holds one busy bitmap. Set bits mark slots busy; clear bits free them.
// The reset value is taken from `preset`.
// Assumes: set and clear masks never overlap, and set only touches free bits.
module slot_bitmap #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] preset,
    input  logic [WIDTH-1:0] set_mask,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] map
);
    // Load the preset on reset, then apply frees and grants each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map <= preset;
        end else begin
            map <= (map & ~clr_mask) | set_mask;
        end
    end

    AST_GRANT_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask & map) == '0); // R5

    AST_SET_CLEAR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask & clr_mask) == '0); // R5

endmodule

// File: rtl/slot_alloc.sv
// Module: slot_alloc
// Grants runs of contiguous scratch slots, searching first the requesting
// queue's private bitmap and then a shared bitmap. A request that finds no
// room stays refused until a release to the shared bitmap occurs.
// Assumes: one requester port; the requester holds its request until
// accepted; counts lie in 1..MAX_RUN; releases name runs that were granted.
module slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int NUM_REGIONS      = 8,
    parameter int SLOTS_PER_REGION = 16,
    parameter int NUM_QUEUES       = 4,
    parameter int MAX_RUN          = 4,
    localparam int TOTAL_SLOTS     = NUM_REGIONS * SLOTS_PER_REGION,
    localparam int SLOT_W          = $clog2(TOTAL_SLOTS),
    localparam int OFF_W           = $clog2(SLOTS_PER_REGION),
    localparam int REG_W           = $clog2(NUM_REGIONS),
    localparam int QID_W           = $clog2(NUM_QUEUES),
    localparam int CNT_W           = $clog2(MAX_RUN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_REGIONS-1:0] region_reserved,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [QID_W-1:0]       req_queue,
    input  logic                   req_has_priv,
    input  logic [REG_W-1:0]       req_priv_region,
    input  logic [CNT_W-1:0]       req_count,
    output logic                   grant_valid,
    output logic [SLOT_W-1:0]      grant_slot,
    input  logic                   rel_valid,
    input  logic [QID_W-1:0]       rel_queue,
    input  logic                   rel_has_priv,
    input  logic [REG_W-1:0]       rel_priv_region,
    input  logic [SLOT_W-1:0]      rel_start,
    input  logic [CNT_W-1:0]       rel_count
);
    logic [SLOTS_PER_REGION-1:0] priv_map [NUM_QUEUES];
    logic [SLOTS_PER_REGION-1:0] priv_view;
    logic [TOTAL_SLOTS-1:0]      sh_map;
    logic [TOTAL_SLOTS-1:0]      sh_preset;
    logic [TOTAL_SLOTS-1:0]      sh_set;
    logic [TOTAL_SLOTS-1:0]      sh_clr;

    logic              pf_found;
    logic [OFF_W-1:0]  pf_idx;
    logic              sf_found;
    logic [SLOT_W-1:0] sf_idx;

    logic hit_priv;
    logic hit_sh;
    logic accept;
    logic blocked;
    logic rel_to_priv;
    logic rel_to_sh;

    // Expand the per-region reserve flags into the shared reset image.
    always_comb begin
        for (int j = 0; j < TOTAL_SLOTS; j++) begin
            sh_preset[j] = region_reserved[j / SLOTS_PER_REGION];
        end
    end

    // Select the requesting queue's private bitmap for the search.
    assign priv_view = priv_map[req_queue];

    slot_run_finder #(
        .WIDTH   (SLOTS_PER_REGION),
        .MAX_RUN (MAX_RUN),
        .CNT_W   (CNT_W),
        .IDX_W   (OFF_W)
    ) u_priv_find (
        .clk   (clk),
        .rst_n (rst_n),
        .map   (priv_view),
        .count (req_count),
        .found (pf_found),
        .idx   (pf_idx)
    );

    slot_run_finder #(
        .WIDTH   (TOTAL_SLOTS),
        .MAX_RUN (MAX_RUN),
        .CNT_W   (CNT_W),
        .IDX_W   (SLOT_W)
    ) u_sh_find (
        .clk   (clk),
        .rst_n (rst_n),
        .map   (sh_map),
        .count (req_count),
        .found (sf_found),
        .idx   (sf_idx)
    );

    // Choose the source: private first, shared as the fallback.
    always_comb begin
        hit_priv  = req_has_priv && pf_found;
        hit_sh    = !hit_priv && sf_found;
        req_ready = req_valid && !blocked && (hit_priv || hit_sh);
        accept    = req_ready;
    end

    // Route a release by whether its start lies in the private region.
    always_comb begin
        rel_to_priv = rel_valid && rel_has_priv
                      && (rel_start[SLOT_W-1:OFF_W] == rel_priv_region);
        rel_to_sh   = rel_valid && !rel_to_priv;
    end

    // Build the shared grant and release masks.
    always_comb begin
        for (int j = 0; j < TOTAL_SLOTS; j++) begin
            sh_set[j] = accept && hit_sh
                        && run_covers(j, int'(sf_idx), int'(req_count));
            sh_clr[j] = rel_to_sh
                        && run_covers(j, int'(rel_start), int'(rel_count));
        end
    end

    slot_bitmap #(
        .WIDTH (TOTAL_SLOTS)
    ) u_sh_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (sh_preset),
        .set_mask (sh_set),
        .clr_mask (sh_clr),
        .map      (sh_map)
    );

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_priv
        logic [SLOTS_PER_REGION-1:0] p_set;
        logic [SLOTS_PER_REGION-1:0] p_clr;

        // Build this queue's private grant and release masks.
        always_comb begin
            for (int j = 0; j < SLOTS_PER_REGION; j++) begin
                p_set[j] = accept && hit_priv && (req_queue == QID_W'(q))
                           && run_covers(j, int'(pf_idx), int'(req_count));
                p_clr[j] = rel_to_priv && (rel_queue == QID_W'(q))
                           && run_covers(j, int'(rel_start[OFF_W-1:0]),
                                         int'(rel_count));
            end
        end

        slot_bitmap #(
            .WIDTH (SLOTS_PER_REGION)
        ) u_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .preset   ('0),
            .set_mask (p_set),
            .clr_mask (p_clr),
            .map      (priv_map[q])
        );
    end

    // Track a refused request; a shared release or a withdrawal clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else if (!req_valid || rel_to_sh) begin
            blocked <= 1'b0;
        end else if (!blocked && !(hit_priv || hit_sh)) begin
            blocked <= 1'b1;
        end
    end

    // Register the grant pulse and the global slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_slot  <= '0;
        end else begin
            grant_valid <= accept;
            if (accept) begin
                grant_slot <= hit_priv ? {req_priv_region, pf_idx} : sf_idx;
            end
        end
    end

    AST_ACCEPT_THEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> grant_valid); // R1

    AST_GRANT_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(req_valid && req_ready)); // R1

    AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !req_ready); // R1

    AST_PRIV_GRANT_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_priv) |=> (grant_slot[SLOT_W-1:OFF_W] == $past(req_priv_region))); // R2

    AST_REFUSED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !rel_to_sh) |=> !req_ready); // R6

endmodule

// File: tb/slot_alloc_tb.sv
module slot_alloc_tb;
    localparam int NR  = 8;
    localparam int SPR = 16;
    localparam int NQ  = 4;
    localparam int TOT = NR * SPR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] region_reserved = 8'b0000_1111;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_queue = '0;
    logic       req_has_priv = 1'b0;
    logic [2:0] req_priv_region = '0;
    logic [2:0] req_count = '0;
    logic       grant_valid;
    logic [6:0] grant_slot;
    logic       rel_valid = 1'b0;
    logic [1:0] rel_queue = '0;
    logic       rel_has_priv = 1'b0;
    logic [2:0] rel_priv_region = '0;
    logic [6:0] rel_start = '0;
    logic [2:0] rel_count = '0;

    slot_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .region_reserved(region_reserved),
        .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
        .req_has_priv(req_has_priv), .req_priv_region(req_priv_region),
        .req_count(req_count), .grant_valid(grant_valid), .grant_slot(grant_slot),
        .rel_valid(rel_valid), .rel_queue(rel_queue), .rel_has_priv(rel_has_priv),
        .rel_priv_region(rel_priv_region), .rel_start(rel_start), .rel_count(rel_count)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit pmap [NQ][SPR];
    bit smap [TOT];
    int al_start [64];
    int al_cnt [64];
    int al_q [64];
    int n_al = 0;
    int last_grant = -1;

    function automatic bit q_has_priv(int q); return q < 3; endfunction
    function automatic int q_region(int q); return q_has_priv(q) ? q + 1 : 0; endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int find_priv(int q, int c);
        for (int o = 0; o + c <= SPR; o++) begin
            bit ok = 1'b1;
            for (int k = 0; k < c; k++) if (pmap[q][o + k]) ok = 1'b0;
            if (ok) return o;
        end
        return -1;
    endfunction

    function automatic int find_sh(int c);
        for (int o = 0; o + c <= TOT; o++) begin
            bit ok = 1'b1;
            for (int k = 0; k < c; k++) if (smap[o + k]) ok = 1'b0;
            if (ok) return o;
        end
        return -1;
    endfunction

    function automatic int find_al(int s);
        for (int i = 0; i < n_al; i++) if (al_start[i] == s) return i;
        return -1;
    endfunction

    // Model of a release, routed as R8 states.
    function automatic void model_rel(int q, int s, int c);
        if (q_has_priv(q) && (s / SPR) == q_region(q))
            for (int k = 0; k < c; k++) pmap[q][(s % SPR) + k] = 1'b0;
        else
            for (int k = 0; k < c; k++) smap[s + k] = 1'b0;
    endfunction

    // Present one request; expect a grant or a refusal from the model.
    task automatic do_req(int q, int c, string tag);
        int p, exp;
        bit from_priv;
        p = q_has_priv(q) ? find_priv(q, c) : -1;
        from_priv = (p >= 0);
        exp = from_priv ? q_region(q) * SPR + p : find_sh(c);
        @(negedge clk);
        req_valid = 1'b1; req_queue = 2'(q); req_has_priv = q_has_priv(q);
        req_priv_region = 3'(q_region(q)); req_count = 3'(c);
        #1;
        check(req_ready == (exp >= 0), tag, int'(req_ready), int'(exp >= 0));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp >= 0) begin
            check(grant_valid && int'(grant_slot) == exp, tag, int'(grant_slot), exp);
            last_grant = exp;
            for (int k = 0; k < c; k++) begin
                if (from_priv) pmap[q][p + k] = 1'b1;
                else smap[exp + k] = 1'b1;
            end
            al_start[n_al] = exp; al_cnt[n_al] = c; al_q[n_al] = q; n_al++;
        end else begin
            check(!grant_valid, tag, int'(grant_valid), 0);
            last_grant = -1;
            @(posedge clk);
        end
    endtask

    // Drive one release port transaction for list entry i.
    task automatic do_rel(int i);
        rel_valid = 1'b1; rel_queue = 2'(al_q[i]); rel_has_priv = q_has_priv(al_q[i]);
        rel_priv_region = 3'(q_region(al_q[i])); rel_start = 7'(al_start[i]);
        rel_count = 3'(al_cnt[i]);
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
        model_rel(al_q[i], al_start[i], al_cnt[i]);
        n_al--;
        al_start[i] = al_start[n_al]; al_cnt[i] = al_cnt[n_al]; al_q[i] = al_q[n_al];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        int r;
        void'($urandom(32'd2024));
        for (int j = 0; j < TOT; j++) smap[j] = (j / SPR) < 4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!grant_valid, "R10", int'(grant_valid), 0);
        check(!req_ready, "R1", int'(req_ready), 0);

        do_req(0, 3, "R2");  check(last_grant == 16, "R2", last_grant, 16);
        do_req(0, 4, "R5");  check(last_grant == 19, "R5", last_grant, 19);
        do_req(0, 4, "R5");
        do_req(0, 4, "R5");
        do_req(0, 4, "R4");  check(last_grant == 64, "R4", last_grant, 64);
        do_req(0, 1, "R2");  check(last_grant == 31, "R2", last_grant, 31);
        do_req(3, 2, "R9");  check(last_grant == 68, "R9", last_grant, 68);
        do_req(1, 4, "R2");  check(last_grant == 32, "R2", last_grant, 32);
        while (find_sh(4) >= 0) do_req(3, 4, "R3");

        // R6: refused while held; a private release does not wake it.
        @(negedge clk);
        req_valid = 1'b1; req_queue = 2'd0; req_has_priv = 1'b1;
        req_priv_region = 3'd1; req_count = 3'd4;
        #1;
        check(!req_ready, "R6", int'(req_ready), 0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk); #1;
            check(!req_ready, "R6", int'(req_ready), 0);
        end
        do_rel(find_al(19));
        #1;
        check(!req_ready, "R6", int'(req_ready), 0);
        // R7: a shared release wakes it; private run at 19 is taken.
        do_rel(find_al(70));
        #1;
        check(req_ready, "R7", int'(req_ready), 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check(grant_valid && grant_slot == 7'd19, "R7", int'(grant_slot), 19);
        for (int k = 0; k < 4; k++) pmap[0][3 + k] = 1'b1;
        al_start[n_al] = 19; al_cnt[n_al] = 4; al_q[n_al] = 0; n_al++;
        @(posedge clk);

        // R8: shared-routed release by a private-owning queue.
        @(negedge clk);
        do_rel(find_al(64));
        do_req(3, 4, "R8");  check(last_grant == 64, "R8", last_grant, 64);
        @(negedge clk);
        do_rel(find_al(16));
        do_req(0, 3, "R8");  check(last_grant == 16, "R8", last_grant, 16);

        // Seeded random mix against the model.
        for (int it = 0; it < 400; it++) begin
            r = int'($urandom_range(99));
            if (n_al > 0 && (r < 40 || n_al >= 60)) begin
                @(negedge clk);
                do_rel(int'($urandom_range(n_al - 1)));
            end else begin
                do_req(int'($urandom_range(NQ - 1)), int'($urandom_range(4, 1)), "R4");
            end
        end
        while (n_al > 0) begin
            @(negedge clk);
            do_rel(0);
        end
        do_req(3, 4, "R9");  check(last_grant == 64, "R9", last_grant, 64);
        report();
    end
endmodule